// File: doc/BRIEF.md
# Three-Phase Center-Aligned PWM Generator

This block drives three inverter legs from one shared time base. Each leg has a high-side output and a low-side output, and these two outputs are complementary. One counter counts up through the first half of a PWM period and back down through the second half. Each leg compares the counter against its own duty value. A dead-time count moves every switching edge of a leg by the same number of clocks away from its ideal position, so the two outputs of a leg are never on together. All durations are whole clock ticks.

A narrow write port loads a set of shadow registers: the half-period length, three duty values, the dead time and the sync-pulse width. The counter uses working copies of these registers, taken from the shadow set at fixed points:

- In single update mode the copy is taken once per period, so the two halves mirror each other.
- In double update mode the copy is also taken at the centre of the period. The second half can then have its own length, duties and dead time.

Every output stays low until the half-period register and all three duty registers have each been written at least once. A sync pulse marks the start of each period, and a status output shows which half is running.

Top module: `tri_leg_pwm`

## Requirements
- R1: After reset, all six leg outputs, the sync output and the status output are low. They stay low until address 0 and addresses 1, 2 and 3 have each been written at least once. The first period tick is the second clock cycle after the edge that captures the last of these writes.
- R2: The write addresses are: 0 for the half-period length T, 1, 2 and 3 for the duty of legs 0, 1 and 2, 4 for the dead time, and 5 for the sync width. Writes to addresses 6 and 7 have no effect and do not count toward enabling the block.
- R3: Within a half of length T, the tick count c runs 0..T-1 in the first half and T-1..0 in the second half. The high-side output of a leg is on exactly when c + duty >= T + deadtime. A duty below the dead time therefore keeps it off, and a duty of at least T + deadtime keeps it on.
- R4: The low-side output of a leg is on exactly when c + duty + deadtime < T. The high-side and low-side outputs of a leg are never on together.
- R5: In single update mode, a period is 2T ticks and each output is symmetric about the period centre.
- R6: In single update mode, a register write made during a period takes effect at the start of the next period, not at the centre.
- R7: In double update mode, the working registers are also loaded from the shadow set at the start of the second half. The second half then lasts its own T2 ticks, so the period is T1 + T2 ticks.
- R8: The sync output is high for the first (syncwidth + 1) ticks of each period, and never during the second half.
- R9: The status output is 0 during the first half of a period and 1 during the second half.
- R10: All three legs share the same count and dead time, and each leg uses only its own duty value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; one tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbl_upd | input | 1 | 1 selects double update mode, 0 selects single update mode |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | CNT_W | Write data; the dead-time and sync registers take the low bits |
| pwm_hi | output | 3 | High-side output, one bit per leg |
| pwm_lo | output | 3 | Low-side output, one bit per leg |
| sync_o | output | 1 | Pulse at the start of each period |
| half_o | output | 1 | Active half: 0 for the first half, 1 for the second |

## Verification
The bench sweeps duty through every value from 0 to beyond T + deadtime, for several half lengths including T = 1 and several dead times. This exposes clamping errors: a design that wraps a negative on-time would turn an output fully on where it should stay off. The sweep also uses sync widths longer than a half, which exposes a pulse that spills into the second half.

A half-written register set, and writes to addresses 6 and 7, must leave the outputs dead. A design that arms early would start switching. Writes made in the middle of a period check the two update modes. A single-mode design that reloaded at the centre would produce an asymmetric period. A double-mode design that skipped the centre reload would keep the old half length.

// File: rtl/tlpwm_pkg.sv
package tlpwm_pkg;

   typedef enum logic [2:0] {
      ADR_HALF   = 3'd0,
      ADR_DUTY_0 = 3'd1,
      ADR_DUTY_1 = 3'd2,
      ADR_DUTY_2 = 3'd3,
      ADR_DEAD   = 3'd4,
      ADR_SYNC   = 3'd5
   } reg_addr_e;

   localparam int NUM_LEGS = 3;

endpackage

// File: rtl/tlpwm_regs.sv
module tlpwm_regs
   import tlpwm_pkg::*;
#(
   parameter int CNT_W = 8,
   parameter int DT_W  = 6,
   parameter int SW_W  = 6
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               wr_en,
   input  logic [2:0]                         wr_addr,
   input  logic [CNT_W-1:0]                   wr_data,
   output logic [CNT_W-1:0]                   sh_tm,
   output logic [NUM_LEGS-1:0][CNT_W-1:0]     sh_duty,
   output logic [DT_W-1:0]                    sh_dt,
   output logic [SW_W-1:0]                    sh_sw,
   output logic                               armed
);

   logic [NUM_LEGS:0] seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_tm     <= '0;
         sh_dt     <= '0;
         sh_sw     <= '0;
         seen_q[0] <= 1'b0;
      end else if (wr_en) begin
         if (wr_addr == ADR_HALF) begin
            sh_tm     <= wr_data;
            seen_q[0] <= 1'b1;
         end
         if (wr_addr == ADR_DEAD) sh_dt <= wr_data[DT_W-1:0];
         if (wr_addr == ADR_SYNC) sh_sw <= wr_data[SW_W-1:0];
      end
   end

   for (genvar g = 0; g < NUM_LEGS; g++) begin : g_duty
      localparam logic [2:0] MY_ADR = 3'(int'(ADR_DUTY_0) + g);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sh_duty[g]  <= '0;
            seen_q[g+1] <= 1'b0;
         end else if (wr_en && wr_addr == MY_ADR) begin
            sh_duty[g]  <= wr_data;
            seen_q[g+1] <= 1'b1;
         end
      end
   end

   assign armed = &seen_q;

endmodule

// File: rtl/tlpwm_timebase.sv
module tlpwm_timebase
   import tlpwm_pkg::*;
#(
   parameter int CNT_W = 8,
   parameter int DT_W  = 6,
   parameter int SW_W  = 6
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               dbl_upd,
   input  logic                               armed,
   input  logic [CNT_W-1:0]                   sh_tm,
   input  logic [NUM_LEGS-1:0][CNT_W-1:0]     sh_duty,
   input  logic [DT_W-1:0]                    sh_dt,
   input  logic [SW_W-1:0]                    sh_sw,
   output logic                               run,
   output logic                               half,
   output logic [CNT_W-1:0]                   cnt,
   output logic [CNT_W-1:0]                   w_tm,
   output logic [NUM_LEGS-1:0][CNT_W-1:0]     w_duty,
   output logic [DT_W-1:0]                    w_dt,
   output logic                               sync
);

   localparam int XW = CNT_W + 1;

   logic [SW_W-1:0]  w_sw;
   logic             last_up;
   logic             at_zero;
   logic             load;
   logic [CNT_W-1:0] next_top;

   // end of the rising half: cnt + 1 >= T (a T of 0 acts as 1)
   assign last_up  = (XW'(cnt) + XW'(1)) >= XW'(w_tm);
   assign at_zero  = (cnt == '0);
   assign load     = (!run && armed)
                   || (run && !half && last_up && dbl_upd)
                   || (run && half && at_zero);
   assign next_top = dbl_upd ? ((sh_tm == '0) ? '0 : sh_tm - 1'b1) : cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run  <= 1'b0;
         half <= 1'b0;
         cnt  <= '0;
      end else if (!run) begin
         if (armed) begin
            run  <= 1'b1;
            half <= 1'b0;
            cnt  <= '0;
         end
      end else if (!half) begin
         if (last_up) begin
            half <= 1'b1;
            cnt  <= next_top;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end else begin
         if (at_zero) half <= 1'b0;
         else         cnt  <= cnt - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         w_tm   <= '0;
         w_duty <= '0;
         w_dt   <= '0;
         w_sw   <= '0;
      end else if (load) begin
         w_tm   <= sh_tm;
         w_duty <= sh_duty;
         w_dt   <= sh_dt;
         w_sw   <= sh_sw;
      end
   end

   assign sync = run && !half && (XW'(cnt) <= XW'(w_sw));

endmodule

// File: rtl/tlpwm_leg.sv
module tlpwm_leg #(
   parameter int CNT_W   = 8,
   parameter int DT_W    = 6,
   parameter bit REG_OUT = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] tm,
   input  logic [CNT_W-1:0] duty,
   input  logic [DT_W-1:0]  dt,
   output logic             hi_o,
   output logic             lo_o
);

   localparam int EW = CNT_W + 2;

   logic [EW-1:0] c_plus_d;
   logic          hi_c;
   logic          lo_c;

   assign c_plus_d = EW'(cnt) + EW'(duty);
   assign hi_c     = en && (c_plus_d >= (EW'(tm) + EW'(dt)));
   assign lo_c     = en && ((c_plus_d + EW'(dt)) < EW'(tm));

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hi_o <= 1'b0;
            lo_o <= 1'b0;
         end else begin
            hi_o <= hi_c;
            lo_o <= lo_c;
         end
      end
   end else begin : g_comb
      assign hi_o = hi_c;
      assign lo_o = lo_c;
   end

endmodule

// File: rtl/tri_leg_pwm.sv
module tri_leg_pwm
   import tlpwm_pkg::*;
#(
   parameter int CNT_W   = 8,
   parameter int DT_W    = 6,
   parameter int SW_W    = 6,
   parameter bit REG_OUT = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dbl_upd,
   input  logic             wr_en,
   input  logic [2:0]       wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   output logic [2:0]       pwm_hi,
   output logic [2:0]       pwm_lo,
   output logic             sync_o,
   output logic             half_o
);

   if (CNT_W < 2 || DT_W > CNT_W || SW_W > CNT_W || DT_W < 1 || SW_W < 1) begin : g_bad_cfg
      $error("tri_leg_pwm: widths need 1 <= DT_W, SW_W <= CNT_W and CNT_W >= 2");
   end

   logic [CNT_W-1:0]                sh_tm;
   logic [NUM_LEGS-1:0][CNT_W-1:0]  sh_duty;
   logic [DT_W-1:0]                 sh_dt;
   logic [SW_W-1:0]                 sh_sw;
   logic                            armed;
   logic                            run;
   logic                            half;
   logic [CNT_W-1:0]                cnt;
   logic [CNT_W-1:0]                w_tm;
   logic [NUM_LEGS-1:0][CNT_W-1:0]  w_duty;
   logic [DT_W-1:0]                 w_dt;
   logic                            sync;

   tlpwm_regs #(.CNT_W(CNT_W), .DT_W(DT_W), .SW_W(SW_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .sh_tm   (sh_tm),
      .sh_duty (sh_duty),
      .sh_dt   (sh_dt),
      .sh_sw   (sh_sw),
      .armed   (armed)
   );

   tlpwm_timebase #(.CNT_W(CNT_W), .DT_W(DT_W), .SW_W(SW_W)) u_tb (
      .clk     (clk),
      .rst_n   (rst_n),
      .dbl_upd (dbl_upd),
      .armed   (armed),
      .sh_tm   (sh_tm),
      .sh_duty (sh_duty),
      .sh_dt   (sh_dt),
      .sh_sw   (sh_sw),
      .run     (run),
      .half    (half),
      .cnt     (cnt),
      .w_tm    (w_tm),
      .w_duty  (w_duty),
      .w_dt    (w_dt),
      .sync    (sync)
   );

   for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
      tlpwm_leg #(.CNT_W(CNT_W), .DT_W(DT_W), .REG_OUT(REG_OUT)) u_leg (
         .clk   (clk),
         .rst_n (rst_n),
         .en    (run),
         .cnt   (cnt),
         .tm    (w_tm),
         .duty  (w_duty[g]),
         .dt    (w_dt),
         .hi_o  (pwm_hi[g]),
         .lo_o  (pwm_lo[g])
      );
   end

   assign sync_o = sync;
   assign half_o = half;

endmodule

// File: rtl/tlpwm_chk.sv
module tlpwm_chk #(
   parameter int DT_W = 6
) (
   input logic            clk,
   input logic            rst_n,
   input logic            dbl_upd,
   input logic            armed,
   input logic [DT_W-1:0] w_dt,
   input logic [2:0]      pwm_hi,
   input logic [2:0]      pwm_lo,
   input logic            sync_o,
   input logic            half_o
);

   AST_QUIET_UNTIL_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |-> (pwm_hi == 3'b000 && pwm_lo == 3'b000 && !sync_o && !half_o)); // R1

   AST_SYNC_OPENS_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(half_o) |-> sync_o); // R8

   for (genvar g = 0; g < 3; g++) begin : g_leg_chk
      AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
         !(pwm_hi[g] && pwm_lo[g])); // R4

      AST_DEAD_GAP_HI: assert property (@(posedge clk) disable iff (!rst_n)
         ($rose(pwm_hi[g]) && !sync_o && !dbl_upd && w_dt != '0) |-> !$past(pwm_lo[g])); // R3

      AST_DEAD_GAP_LO: assert property (@(posedge clk) disable iff (!rst_n)
         ($rose(pwm_lo[g]) && !sync_o && !dbl_upd && w_dt != '0) |-> !$past(pwm_hi[g])); // R4
   end

endmodule

bind tri_leg_pwm tlpwm_chk #(.DT_W(DT_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .dbl_upd (dbl_upd),
   .armed   (armed),
   .w_dt    (w_dt),
   .pwm_hi  (pwm_hi),
   .pwm_lo  (pwm_lo),
   .sync_o  (sync_o),
   .half_o  (half_o)
);

// File: tb/sim_tri_leg_pwm.sv
`timescale 1ns/1ps
module sim_tri_leg_pwm;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       dbl_upd = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = 3'd0;
   logic [7:0] wr_data = 8'd0;
   logic [2:0] pwm_hi;
   logic [2:0] pwm_lo;
   logic       sync_o;
   logic       half_o;

   int  n_chk  = 0;
   int  n_fail = 0;
   bit  done   = 1'b0;
   int  qa[8];
   int  qd[8];
   int  qn = 0;
   int  qi = 0;

   always #5 clk = ~clk;

   tri_leg_pwm u0 (
      .clk     (clk),
      .rst_n   (rst_n),
      .dbl_upd (dbl_upd),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .pwm_hi  (pwm_hi),
      .pwm_lo  (pwm_lo),
      .sync_o  (sync_o),
      .half_o  (half_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
      end
   endtask

   task automatic chk_idle(input string req);
      int act;
      act = {pwm_hi, pwm_lo, sync_o, half_o};
      chk(act == 0, req, act, 0);
   endtask

   task automatic do_reset(input bit mode);
      @(negedge clk);
      rst_n   = 1'b0;
      wr_en   = 1'b0;
      dbl_upd = mode;
      qn = 0;
      qi = 0;
      repeat (2) @(negedge clk);
      chk_idle("R1 reset");
      rst_n = 1'b1;
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_addr = 3'(a);
      wr_data = 8'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic queue_wr(input int a, input int d);
      qa[qn] = a;
      qd[qn] = d;
      qn++;
   endtask

   // one half of a period; called at the negedge of its first tick
   task automatic run_half(input int t, input int d0, input int d1, input int d2,
                           input int dt, input int sw, input int h);
      int d[3];
      d[0] = d0; d[1] = d1; d[2] = d2;
      for (int j = 0; j < t; j++) begin
         int c;
         int eh;
         int el;
         int es;
         c  = (h != 0) ? (t - 1 - j) : j;
         eh = 0;
         el = 0;
         for (int p = 0; p < 3; p++) begin
            if (c + d[p] >= t + dt) eh |= (1 << p);
            if (c + d[p] + dt < t)  el |= (1 << p);
         end
         es = (h == 0 && c <= sw) ? 1 : 0;
         chk(int'(pwm_hi) == eh, "R3 R10 high side", int'(pwm_hi), eh);
         chk(int'(pwm_lo) == el, "R4 low side", int'(pwm_lo), el);
         chk(int'(sync_o) == es, "R8 sync", int'(sync_o), es);
         chk(int'(half_o) == h,  "R9 status", int'(half_o), h);
         if (qi < qn) begin
            wr_en   = 1'b1;
            wr_addr = 3'(qa[qi]);
            wr_data = 8'(qd[qi]);
            qi++;
         end else begin
            wr_en = 1'b0;
         end
         @(negedge clk);
      end
      wr_en = 1'b0;
   endtask

   task automatic program_all(input int t, input int d0, input int d1, input int d2,
                              input int dt, input int sw);
      wr(5, sw);
      wr(4, dt);
      wr(0, t);
      wr(1, d0);
      wr(2, d1);
      wr(3, d2);
      chk_idle("R1 armed, not yet started");
      @(negedge clk);
   endtask

   initial begin
      int tl[4];
      tl[0] = 1; tl[1] = 2; tl[2] = 5; tl[3] = 8;

      // R1 and R2: a partial register set plus writes to unused addresses
      do_reset(1'b0);
      wr(4, 1);
      wr(5, 0);
      wr(0, 4);
      wr(1, 2);
      wr(2, 3);
      wr(6, 9);
      wr(7, 9);
      for (int k = 0; k < 12; k++) begin
         chk_idle("R1 R2 idle without leg 2 duty");
         @(negedge clk);
      end
      wr(3, 6);
      chk_idle("R1 armed, not yet started");
      @(negedge clk);
      run_half(4, 2, 3, 6, 1, 0, 0);
      run_half(4, 2, 3, 6, 1, 0, 1);

      // R5: single update sweep over T, dead time and duty, two periods each
      for (int ti = 0; ti < 4; ti++) begin
         for (int dt = 0; dt < 4; dt += 1) begin
            int t;
            t = tl[ti];
            for (int dd = 0; dd <= t + dt + 1; dd++) begin
               int d1;
               int sw;
               d1 = t + dt + 1 - dd;
               sw = dd % (t + 2);
               do_reset(1'b0);
               program_all(t, dd, d1, dd / 2, dt, sw);
               for (int per = 0; per < 2; per++) begin
                  run_half(t, dd, d1, dd / 2, dt, sw, 0);
                  run_half(t, dd, d1, dd / 2, dt, sw, 1);
               end
            end
         end
      end

      // R6: single mode, writes in the first half wait for the next period
      do_reset(1'b0);
      program_all(6, 2, 4, 5, 1, 1);
      queue_wr(1, 5);
      queue_wr(4, 0);
      run_half(6, 2, 4, 5, 1, 1, 0);
      run_half(6, 2, 4, 5, 1, 1, 1);
      run_half(6, 5, 4, 5, 0, 1, 0);
      run_half(6, 5, 4, 5, 0, 1, 1);

      // R7: double mode, new values at the centre and again at the next centre
      do_reset(1'b1);
      program_all(6, 3, 1, 6, 1, 2);
      queue_wr(0, 3);
      queue_wr(1, 2);
      queue_wr(4, 0);
      run_half(6, 3, 1, 6, 1, 2, 0);
      run_half(3, 2, 1, 6, 0, 2, 1);
      queue_wr(0, 4);
      queue_wr(2, 3);
      run_half(3, 2, 1, 6, 0, 2, 0);
      run_half(4, 2, 3, 6, 0, 2, 1);
      run_half(4, 2, 3, 6, 0, 2, 0);

      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule